// File: doc/BRIEF.md
# Fs/4 Complex-to-Real IF Converter

The converter takes a complex baseband stream, one signed I/Q pair per clock, and turns it into a real intermediate-frequency stream. A two-bit mode input selects one of four behaviours:

- **Pass-through:** I and Q go through unchanged.
- **Single rate:** the pair is band-limited by a 7-tap half-band filter with kernel [-1, 0, 9, 16, 9, 0, -1]/32. It is then moved up by a quarter of the sample rate, and only the real part is kept at the input rate.
- **Double rate:** the pair is interpolated by two through a two-phase split of the same half-band kernel. It is shifted up by half the input rate, and the two real output samples of each clock leave on the I and Q outputs.
- **Mute:** both outputs are zero.

The quarter-rate rotation multiplies by e^{j(pi/2)m}. It is built from negation and selection only; there is no multiplier.

Notation: x[k] is the input sampled at rising edge k. Every result derived from samples up to x[k] is registered at edge k+1, so it is visible at the outputs after edge k+1. The sample index n counts edges since the last mode change. All arithmetic is W-bit two's complement, and every result is saturated to [-2^(W-1), 2^(W-1)-1].

A mode change restarts the rotation phase and discards the filter history. The output is held at zero until the delay line holds only samples taken in the new mode.

Top module: `ifc_fs4_conv`

## Requirements
- R1: With mode 2'b00, out_i and out_q equal in_i and in_q of x[k] after edge k+1 (two-edge latency, values unchanged).
- R2: With mode 2'b11, out_i and out_q are both zero.
- R3: With mode 2'b01 and no hold active, out_q is zero and out_i = +fI, -fQ, -fI, +fQ for n mod 4 = 0, 1, 2, 3, where fI and fQ are the R4 filter outputs of the I and Q channels at sample k.
- R4: The single-rate filter output is sat(floor((16 + 9*x[k-2] + 16*x[k-3] + 9*x[k-4] - x[k] - x[k-6]) / 32)).
- R5: With mode 2'b10 and no hold active, out_i carries the first output sample and out_q the second. The first is e = sat(floor((8 + 9*xI[k-1] + 9*xI[k-2] - xI[k] - xI[k-3]) / 16)), sent as e for even n and -e for odd n. The second is xQ[k-1], sent negated for even n and as is for odd n.
- R6: Every negation saturates, so the most negative value -2^(W-1) becomes 2^(W-1)-1.
- R7: A sample whose mode differs from the mode of the previous edge has n = 0. In mode 2'b01 both outputs stay zero while n < 6, and in mode 2'b10 while n < 3.
- R8: During and directly after reset, both outputs are zero, and the remembered mode is 2'b00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| mode | input | 2 | 00 pass-through, 01 single-rate real, 10 double-rate real, 11 mute |
| in_i | input | W | In-phase input sample, signed |
| in_q | input | W | Quadrature input sample, signed |
| out_i | output | W | Real output (first sample of the pair at double rate), signed |
| out_q | output | W | Zero at single rate, second real sample at double rate, Q in pass-through |

## Verification
The hardest situation to reach from the ports is a second mode change that lands while the hold window of the first change is still running, so that the phase and fill restart mid-window. The bench reaches it with many short runs of random mode and random length (one to eight samples), plus a directed single-rate/double-rate/single-rate sequence. The other rare case is a filtered or delayed value sitting at exactly -2^(W-1) on a phase that negates it. Constant full-scale negative inputs in both real modes force that value through every phase.

// File: rtl/ifc_fs4_pkg.sv
package ifc_fs4_pkg;

   typedef enum logic [1:0] {
      IFC_BYPASS = 2'd0,
      IFC_REAL1X = 2'd1,
      IFC_REAL2X = 2'd2,
      IFC_MUTE   = 2'd3
   } ifc_mode_e;

   // which half-band result a channel filter hands to the mixer
   typedef enum logic [1:0] {
      HB_FULL = 2'd0,
      HB_EVEN = 2'd1,
      HB_ODD  = 2'd2
   } hb_sel_e;

   localparam int HB_SPAN       = 7;
   localparam int HB_FULL_SHIFT = 5;
   localparam int HB_EVEN_SHIFT = 4;

endpackage

// File: rtl/ifc_hb_filter.sv
module ifc_hb_filter
   import ifc_fs4_pkg::*;
#(
   parameter int W = 12
)
(
   input  logic                clk,
   input  logic                rst_n,
   input  logic signed [W-1:0] din,
   input  hb_sel_e             sel,
   output logic signed [W-1:0] newest_o,
   output logic signed [W-1:0] y_o
);
   localparam int AW       = W + 6;
   localparam int RND_FULL = 1 << (HB_FULL_SHIFT - 1);
   localparam int RND_EVEN = 1 << (HB_EVEN_SHIFT - 1);
   localparam logic signed [AW-1:0] HI = AW'((2 ** (W - 1)) - 1);
   localparam logic signed [AW-1:0] LO = AW'(-(2 ** (W - 1)));

   if (HB_SPAN != 7) begin : g_bad_span
      $error("ifc_hb_filter: kernel is written for seven taps");
   end

   function automatic logic signed [W-1:0] clip(input logic signed [AW-1:0] v);
      if (v > HI)      clip = HI[W-1:0];
      else if (v < LO) clip = LO[W-1:0];
      else             clip = v[W-1:0];
   endfunction

   // delay line, line[0] newest
   logic signed [W-1:0] line [HB_SPAN];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int j = 0; j < HB_SPAN; j++) line[j] <= '0;
      end else begin
         line[0] <= din;
         for (int j = 1; j < HB_SPAN; j++) line[j] <= line[j-1];
      end
   end

   // sign-extended copies of the taps that carry weight (tap 5 is zero-weight)
   logic signed [AW-1:0] e0, e1, e2, e3, e4, e6;
   assign e0 = AW'(line[0]);
   assign e1 = AW'(line[1]);
   assign e2 = AW'(line[2]);
   assign e3 = AW'(line[3]);
   assign e4 = AW'(line[4]);
   assign e6 = AW'(line[6]);

   // single rate: symmetric pair 9*(t2+t4) + 16*t3 - t0 - t6, shift-add only
   logic signed [AW-1:0] pair_f, acc_full;
   assign pair_f   = e2 + e4;
   assign acc_full = (pair_f <<< 3) + pair_f + (e3 <<< 4) - e0 - e6 + AW'(RND_FULL);

   // double rate even phase: taps h0,h2,h4,h6 on x[k..k-3], gain 2 => /16
   logic signed [AW-1:0] pair_e, acc_even;
   assign pair_e   = e1 + e2;
   assign acc_even = (pair_e <<< 3) + pair_e - e0 - e3 + AW'(RND_EVEN);

   logic signed [W-1:0] full_w, even_w;
   assign full_w = clip(acc_full >>> HB_FULL_SHIFT);
   assign even_w = clip(acc_even >>> HB_EVEN_SHIFT);

   // odd phase is the centre tap alone: 16*x[k-1]/16 is exact
   always_comb begin
      case (sel)
         HB_EVEN: y_o = even_w;
         HB_ODD:  y_o = line[1];
         default: y_o = full_w;
      endcase
   end

   assign newest_o = line[0];

endmodule

// File: rtl/ifc_fs4_mix.sv
module ifc_fs4_mix
   import ifc_fs4_pkg::*;
#(
   parameter int W = 12
)
(
   input  ifc_mode_e           mode,
   input  logic [1:0]          phase,
   input  logic                hold,
   input  logic signed [W-1:0] byp_i,
   input  logic signed [W-1:0] byp_q,
   input  logic signed [W-1:0] fil_i,
   input  logic signed [W-1:0] fil_q,
   output logic signed [W-1:0] mix_i,
   output logic signed [W-1:0] mix_q
);
   localparam logic signed [W-1:0] PMAX = {1'b0, {(W-1){1'b1}}};
   localparam logic signed [W-1:0] PMIN = {1'b1, {(W-1){1'b0}}};

   function automatic logic signed [W-1:0] flip(input logic signed [W-1:0] v);
      flip = (v == PMIN) ? PMAX : -v;
   endfunction

   always_comb begin
      mix_i = '0;
      mix_q = '0;
      if (!hold) begin
         case (mode)
            IFC_BYPASS: begin
               mix_i = byp_i;
               mix_q = byp_q;
            end
            IFC_REAL1X: begin
               // Re{(I + jQ) * j^n}: I, -Q, -I, Q
               case (phase)
                  2'd0:    mix_i = fil_i;
                  2'd1:    mix_i = flip(fil_q);
                  2'd2:    mix_i = flip(fil_i);
                  default: mix_i = fil_q;
               endcase
            end
            IFC_REAL2X: begin
               // output index m = 2n, 2n+1; m mod 4 is {0,1} or {2,3}
               mix_i = phase[0] ? flip(fil_i) : fil_i;
               mix_q = phase[0] ? fil_q : flip(fil_q);
            end
            default: begin
               mix_i = '0;
               mix_q = '0;
            end
         endcase
      end
   end

endmodule

// File: rtl/ifc_fs4_conv.sv
module ifc_fs4_conv
   import ifc_fs4_pkg::*;
#(
   parameter int W = 12
)
(
   input  logic                clk,
   input  logic                rst_n,
   input  logic [1:0]          mode,
   input  logic signed [W-1:0] in_i,
   input  logic signed [W-1:0] in_q,
   output logic signed [W-1:0] out_i,
   output logic signed [W-1:0] out_q
);
   localparam int D1X = HB_SPAN - 1;
   localparam int D2X = HB_SPAN / 2;
   localparam int FW  = $clog2(D1X + 1);
   localparam logic signed [W-1:0] PMAX = {1'b0, {(W-1){1'b1}}};
   localparam logic signed [W-1:0] PMIN = {1'b1, {(W-1){1'b0}}};

   if (W < 6 || W > 24) begin : g_bad_w
      $error("ifc_fs4_conv: W must lie in 6..24");
   end

   ifc_mode_e       mode_in, mode_q;
   logic            chg, hold;
   logic [1:0]      phase;
   logic [FW-1:0]   fill, dly;

   assign mode_in = ifc_mode_e'(mode);
   assign chg     = (mode_in != mode_q);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_q <= IFC_BYPASS;
         phase  <= '0;
         fill   <= '0;
      end else begin
         mode_q <= mode_in;
         if (chg) begin
            phase <= '0;
            fill  <= '0;
         end else begin
            phase <= phase + 2'd1;
            if (fill != FW'(D1X)) fill <= fill + 1'b1;
         end
      end
   end

   always_comb begin
      case (mode_q)
         IFC_REAL1X: dly = FW'(D1X);
         IFC_REAL2X: dly = FW'(D2X);
         default:    dly = '0;
      endcase
   end

   assign hold = (fill < dly);

   logic signed [W-1:0] ch_din [2];
   logic signed [W-1:0] ch_new [2];
   logic signed [W-1:0] ch_fil [2];
   hb_sel_e             ch_sel [2];

   assign ch_din[0] = in_i;
   assign ch_din[1] = in_q;

   for (genvar c = 0; c < 2; c++) begin : g_chan
      localparam hb_sel_e SEL_2X = (c == 0) ? HB_EVEN : HB_ODD;
      assign ch_sel[c] = (mode_q == IFC_REAL2X) ? SEL_2X : HB_FULL;
      ifc_hb_filter #(.W(W)) u_hb (
         .clk      (clk),
         .rst_n    (rst_n),
         .din      (ch_din[c]),
         .sel      (ch_sel[c]),
         .newest_o (ch_new[c]),
         .y_o      (ch_fil[c])
      );
   end

   logic signed [W-1:0] mix_i, mix_q;

   ifc_fs4_mix #(.W(W)) u_mix (
      .mode  (mode_q),
      .phase (phase),
      .hold  (hold),
      .byp_i (ch_new[0]),
      .byp_q (ch_new[1]),
      .fil_i (ch_fil[0]),
      .fil_q (ch_fil[1]),
      .mix_i (mix_i),
      .mix_q (mix_q)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_i <= '0;
         out_q <= '0;
      end else begin
         out_i <= mix_i;
         out_q <= mix_q;
      end
   end

   function automatic logic signed [W-1:0] neg_ref(input logic signed [W-1:0] v);
      neg_ref = (v == PMIN) ? PMAX : -v;
   endfunction

   // R1
   bypass_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_q == IFC_BYPASS && fill != '0) |=> (out_i == $past(in_i, 2) && out_q == $past(in_q, 2)));

   // R2
   mute_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_q == IFC_MUTE) |=> (out_i == '0 && out_q == '0));

   // R3
   real1x_q_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_q == IFC_REAL1X) |=> (out_q == '0));

   // R5
   real2x_odd_pos_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_q == IFC_REAL2X && !hold && phase[0]) |=> (out_q == $past(in_q, 3)));

   // R5 R6
   real2x_odd_neg_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_q == IFC_REAL2X && !hold && !phase[0]) |=> (out_q == neg_ref($past(in_q, 3))));

   // R7
   hold_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      hold |=> (out_i == '0 && out_q == '0));

   // R7
   phase_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
      chg |=> (phase == 2'd0 && fill == '0));

endmodule

// File: tb/tb_ifc_fs4_conv.sv
`timescale 1ns/1ps
module tb_ifc_fs4_conv;
   localparam int W    = 12;
   localparam int MAXV = 2047;
   localparam int MINV = -2048;
   localparam int NMAX = 4096;

   logic                clk = 1'b0;
   logic                rst_n = 1'b0;
   logic [1:0]          mode = 2'd0;
   logic signed [W-1:0] in_i = '0;
   logic signed [W-1:0] in_q = '0;
   logic signed [W-1:0] out_i, out_q;

   always #5 clk = ~clk;

   ifc_fs4_conv #(.W(W)) dut (
      .clk(clk), .rst_n(rst_n), .mode(mode),
      .in_i(in_i), .in_q(in_q), .out_i(out_i), .out_q(out_q)
   );

   int xi [NMAX];
   int xq [NMAX];
   int md [NMAX];
   int seg [NMAX];
   int ne = 0;
   int prev_mode = 0;
   int vectors = 0;
   int errors = 0;
   bit done = 1'b0;

   function automatic int sat(input int v);
      if (v > MAXV) return MAXV;
      if (v < MINV) return MINV;
      return v;
   endfunction

   // R6: negation saturates
   function automatic int negs(input int v);
      return sat(-v);
   endfunction

   function automatic int xv(input bit ch, input int k);
      return ch ? xq[k] : xi[k];
   endfunction

   // R4 reference: full half-band, round half up, saturate
   function automatic int hb_full(input bit ch, input int k);
      int acc;
      acc = -xv(ch, k) + 9 * xv(ch, k-2) + 16 * xv(ch, k-3) + 9 * xv(ch, k-4) - xv(ch, k-6);
      return sat((acc + 16) >>> 5);
   endfunction

   function automatic int hb_even(input int k);
      int acc;
      acc = -xi[k] + 9 * xi[k-1] + 9 * xi[k-2] - xi[k-3];
      return sat((acc + 8) >>> 4);
   endfunction

   task automatic compare(input int ei, input int eq, input string tag);
      int ai, aq;
      ai = out_i;
      aq = out_q;
      vectors++;
      if (out_i !== ei[W-1:0] || out_q !== eq[W-1:0]) begin
         errors++;
         $display("FAIL %s at sample %0d: got i=%0d q=%0d, expected i=%0d q=%0d",
                  tag, ne, ai, aq, ei, eq);
      end
   endtask

   task automatic expect_from(input int k);
      int m, n, ei, eq, fi, fq, e;
      string tag;
      m = md[k];
      n = k - seg[k];
      ei = 0; eq = 0;
      case (m)
         0: begin ei = xi[k]; eq = xq[k]; tag = "R1"; end
         3: begin tag = "R2"; end
         1: begin
            if (n < 6) tag = "R7";
            else begin
               tag = "R3/R4";
               fi = hb_full(1'b0, k);
               fq = hb_full(1'b1, k);
               case (n % 4)
                  0: ei = fi;
                  1: ei = negs(fq);
                  2: ei = negs(fi);
                  default: ei = fq;
               endcase
            end
         end
         default: begin
            if (n < 3) tag = "R7";
            else begin
               tag = "R5";
               e = hb_even(k);
               ei = (n % 2 == 1) ? negs(e) : e;
               eq = (n % 2 == 1) ? xq[k-1] : negs(xq[k-1]);
            end
         end
      endcase
      compare(ei, eq, tag);
   endtask

   task automatic step(input int m, input int a, input int b);
      md[ne] = m;
      xi[ne] = a;
      xq[ne] = b;
      if (m != prev_mode) seg[ne] = ne;
      else seg[ne] = (ne == 0) ? -1 : seg[ne-1];
      prev_mode = m;
      mode = m[1:0];
      in_i = a[W-1:0];
      in_q = b[W-1:0];
      @(posedge clk);
      @(negedge clk);
      ne++;
      if (ne == 1) compare(0, 0, "R8");
      else expect_from(ne - 2);
   endtask

   function automatic int rnd();
      return int'($urandom_range(4095)) - 2048;
   endfunction

   initial begin
      // R8: reset holds outputs at zero whatever the inputs do
      repeat (3) begin
         @(negedge clk);
         mode = 2'd1;
         in_i = 12'sd700;
         in_q = -12'sd300;
      end
      @(negedge clk);
      compare(0, 0, "R8");
      mode = 2'd0;
      rst_n = 1'b1;

      // R1 pass-through
      for (int s = 0; s < 40; s++) step(0, rnd(), rnd());
      // R3 R4 single rate, random and impulse
      for (int s = 0; s < 60; s++) step(1, rnd() / 4, rnd() / 4);
      for (int s = 0; s < 8; s++) step(1, 0, 0);
      step(1, 1024, -512);
      for (int s = 0; s < 12; s++) step(1, 0, 0);
      // R4 saturation with full-scale extremes
      for (int s = 0; s < 60; s++)
         step(1, ($urandom_range(1) != 0) ? MAXV : MINV, ($urandom_range(1) != 0) ? MAXV : MINV);
      // R6 constant most-negative input: negated phases must clip
      for (int s = 0; s < 20; s++) step(1, MINV, MINV);
      // R5 double rate
      for (int s = 0; s < 60; s++) step(2, rnd(), rnd());
      for (int s = 0; s < 20; s++) step(2, MINV, MINV);
      for (int s = 0; s < 40; s++)
         step(2, ($urandom_range(1) != 0) ? MAXV : MINV, rnd());
      // R2 mute
      for (int s = 0; s < 20; s++) step(3, rnd(), rnd());
      // R7 change inside a running hold window
      for (int s = 0; s < 3; s++) step(1, rnd(), rnd());
      for (int s = 0; s < 5; s++) step(2, rnd(), rnd());
      for (int s = 0; s < 12; s++) step(1, rnd(), rnd());
      // R7 short random runs of random modes
      for (int r = 0; r < 120; r++) begin
         int m, len;
         m = int'($urandom_range(3));
         len = int'($urandom_range(8, 1));
         for (int s = 0; s < len; s++) step(m, rnd(), rnd());
      end
      for (int s = 0; s < 20; s++) step(0, rnd(), rnd());

      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
   end

   initial begin
      #(200000 * 10);
      if (!done) begin
         errors++;
         $display("FAIL watchdog R1: run did not end, got hung, expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
         $finish;
      end
   end

endmodule